// File: doc/BRIEF.md
# Functional Unit Status Table

This block sits at the issue stage of a processor that has several execution units with different latencies. It keeps one row per execution unit. A row records whether the unit is occupied, and if it is, the operation it runs, the register it will write and the two registers it read. An instruction waiting to issue presents its unit class, opcode, destination and two source register names. The block compares these against every occupied row in parallel. It decides whether the instruction may go and, when it may, which unit row it takes.

The table covers three data hazards: read-after-write, write-after-read and write-after-write. It also tests unit availability. When the instruction is clean, it is written into the lowest-numbered free row of its class. Write-back names the units that have finished with a per-row release mask. A release applies before the same-cycle check, so a unit or register freed in a cycle can be reused in that same cycle. The decision and the row update both take effect on the same clock edge. The block handles only register names and control bits.

Top module: `fu_status_table`

## Requirements
- R1: After synchronous reset all rows are idle, and the grant output and every hazard flag read 0.
- R2: Unit classes are encoded on iss_class as Int=0, Mem=1, Add=2, Mult=3 and Div=4. Rows map to classes in this way: row 0 is Int, row 1 is Mem, rows 2–4 are Add, rows 5–6 are Mult and row 7 is Div. Class codes 5–7 are never granted and raise the no-unit flag.
- R3: An instruction is granted only if at least one row of its class is idle. The granted row is the lowest-numbered idle row of that class, and it is reported on grant_row_q. If no row of the class is idle, the no-unit flag rises.
- R4: The read-after-write flag rises when either source of the issuing instruction equals the destination of an occupied row.
- R5: The write-after-read flag rises when the destination of the issuing instruction equals either source of an occupied row.
- R6: The write-after-write flag rises when the destination of the issuing instruction equals the destination of an occupied row.
- R7: On a grant, the chosen row becomes occupied and holds the instruction's opcode, destination and sources. On any hazard or missing unit, no row changes.
- R8: A release bit clears its row on the next edge. A release in the same cycle as an issue is applied before the check, so the freed unit and its register names can be claimed at once.
- R9: The decision and the flags appear on the registered outputs one clock after the request. With iss_valid low, the grant and all flags are 0 and the table only takes releases.
- R10: Idle rows take part in no comparison, whatever stale names they still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_class | input | 3 | Unit class of the instruction |
| iss_op | input | OP_W | Opcode |
| iss_dest | input | REG_W | Destination register name |
| iss_src1 | input | REG_W | First source register name |
| iss_src2 | input | REG_W | Second source register name |
| wb_release | input | NROWS | Per-row write-back completion mask |
| grant_q | output | 1 | Instruction was dispatched |
| grant_row_q | output | RIDX_W | Row taken by the dispatched instruction |
| raw_q | output | 1 | Read-after-write hazard seen |
| war_q | output | 1 | Write-after-read hazard seen |
| waw_q | output | 1 | Write-after-write hazard seen |
| nounit_q | output | 1 | No idle unit of the class, or an illegal class |
| tbl_busy | output | NROWS | Occupied flag of every row |
| tbl_op | output | NROWS*OP_W | Opcode field of every row, row 0 in the low bits |
| tbl_dest | output | NROWS*REG_W | Destination field of every row, row 0 in the low bits |

## Verification
The bench aims at a release and an issue that hit the same row or register in one cycle. A design that checks before applying the release would stall there, one cycle too long. It also fills the three Add rows and frees the middle one, to catch an allocator that picks the wrong instance or one outside the class. Stale names left in freed rows are used to expose comparisons that ignore the occupied flag, because such a design reports false hazards. A long random run over a small register range drives every hazard kind at the same time, so a flag crossed with another, or a row written despite a hazard, shows up as a mismatch against the reference model.

// File: rtl/fust_pkg.sv
package fust_pkg;

  typedef enum logic [2:0] {
    FC_INT = 3'd0,
    FC_MEM = 3'd1,
    FC_ADD = 3'd2,
    FC_MUL = 3'd3,
    FC_DIV = 3'd4
  } fu_class_e;

  localparam int CLS_W = 3;

  // Class served by a given row: one Int, one Mem, n_add Add rows, n_mul Mult rows, then Div.
  function automatic fu_class_e row_class(input int row, input int n_add, input int n_mul);
    if (row == 0)                    return FC_INT;
    else if (row == 1)               return FC_MEM;
    else if (row < 2 + n_add)        return FC_ADD;
    else if (row < 2 + n_add + n_mul) return FC_MUL;
    else                             return FC_DIV;
  endfunction

endpackage

// File: rtl/fust_table.sv
module fust_table #(
  parameter int NROWS = 8,
  parameter int REG_W = 5,
  parameter int OP_W  = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NROWS-1:0]             release_i,
  input  logic [NROWS-1:0]             wr_en,
  input  logic [OP_W-1:0]              wr_op,
  input  logic [REG_W-1:0]             wr_dest,
  input  logic [REG_W-1:0]             wr_src1,
  input  logic [REG_W-1:0]             wr_src2,
  output logic [NROWS-1:0]             busy_q,
  output logic [NROWS-1:0]             busy_eff,
  output logic [NROWS-1:0][OP_W-1:0]   op_q,
  output logic [NROWS-1:0][REG_W-1:0]  dest_q,
  output logic [NROWS-1:0][REG_W-1:0]  src1_q,
  output logic [NROWS-1:0][REG_W-1:0]  src2_q
);

  // Releases apply ahead of the issue check in the same cycle.
  assign busy_eff = busy_q & ~release_i;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= busy_eff | wr_en;
  end

  // Field storage carries no reset; fields are only meaningful while busy.
  for (genvar r = 0; r < NROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (wr_en[r]) begin
        op_q[r]   <= wr_op;
        dest_q[r] <= wr_dest;
        src1_q[r] <= wr_src1;
        src2_q[r] <= wr_src2;
      end
    end

    // R8: a release not refilled in the same cycle leaves the row idle.
    assert_release_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (release_i[r] && !wr_en[r]) |=> !busy_q[r]);

    // R6: no two occupied rows ever share a destination.
    for (genvar s = r + 1; s < NROWS; s++) begin : g_pair
      assert_unique_dest_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_q[r] && busy_q[s]) |-> (dest_q[r] != dest_q[s]));
    end
  end

  // R7: at most one row is written per cycle, and only an idle one.
  assert_single_write_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en) && ((wr_en & busy_eff) == '0));

endmodule

// File: rtl/fust_match.sv
module fust_match #(
  parameter int NROWS = 8,
  parameter int REG_W = 5
) (
  input  logic [NROWS-1:0]             busy_eff,
  input  logic [NROWS-1:0][REG_W-1:0]  dest_q,
  input  logic [NROWS-1:0][REG_W-1:0]  src1_q,
  input  logic [NROWS-1:0][REG_W-1:0]  src2_q,
  input  logic [REG_W-1:0]             iss_dest,
  input  logic [REG_W-1:0]             iss_src1,
  input  logic [REG_W-1:0]             iss_src2,
  output logic                         raw,
  output logic                         war,
  output logic                         waw
);

  logic [NROWS-1:0] raw_hit, war_hit, waw_hit;

  for (genvar r = 0; r < NROWS; r++) begin : g_cmp
    assign raw_hit[r] = busy_eff[r] &&
                        ((dest_q[r] == iss_src1) || (dest_q[r] == iss_src2));
    assign war_hit[r] = busy_eff[r] &&
                        ((src1_q[r] == iss_dest) || (src2_q[r] == iss_dest));
    assign waw_hit[r] = busy_eff[r] && (dest_q[r] == iss_dest);
  end

  assign raw = |raw_hit;
  assign war = |war_hit;
  assign waw = |waw_hit;

endmodule

// File: rtl/fust_alloc.sv
module fust_alloc
  import fust_pkg::*;
#(
  parameter int NROWS  = 8,
  parameter int N_ADD  = 3,
  parameter int N_MUL  = 2,
  localparam int RIDX_W = (NROWS > 1) ? $clog2(NROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NROWS-1:0]     busy_eff,
  input  logic [CLS_W-1:0]     iss_class,
  output logic                 legal,
  output logic                 found,
  output logic [RIDX_W-1:0]    sel_row,
  output logic [NROWS-1:0]     sel_oh
);

  logic [NROWS-1:0] in_class;
  logic [NROWS-1:0] cand;

  for (genvar r = 0; r < NROWS; r++) begin : g_cls
    localparam fu_class_e RC = row_class(r, N_ADD, N_MUL);
    assign in_class[r] = (iss_class == CLS_W'(RC));
  end

  assign legal = (iss_class <= CLS_W'(FC_DIV));
  assign cand  = in_class & ~busy_eff;

  always_comb begin
    logic seen;
    seen    = 1'b0;
    sel_row = '0;
    sel_oh  = '0;
    for (int r = 0; r < NROWS; r++) begin
      if (cand[r] && !seen) begin
        sel_oh[r] = 1'b1;
        sel_row   = RIDX_W'(r);
      end
      seen = seen | cand[r];
    end
    found = seen;
  end

  // R3: the chosen row is idle and belongs to the requested class.
  assert_pick_in_class_R3: assert property (@(posedge clk) disable iff (rst)
    found |-> (in_class[sel_row] && !busy_eff[sel_row]));

  // R2: an illegal class code never yields a candidate.
  assert_illegal_class_R2: assert property (@(posedge clk) disable iff (rst)
    !legal |-> !found);

endmodule

// File: rtl/fu_status_table.sv
module fu_status_table
  import fust_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int OP_W  = 6,
  parameter int N_ADD = 3,
  parameter int N_MUL = 2,
  localparam int NROWS  = 3 + N_ADD + N_MUL,
  localparam int RIDX_W = (NROWS > 1) ? $clog2(NROWS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     iss_valid,
  input  logic [2:0]               iss_class,
  input  logic [OP_W-1:0]          iss_op,
  input  logic [REG_W-1:0]         iss_dest,
  input  logic [REG_W-1:0]         iss_src1,
  input  logic [REG_W-1:0]         iss_src2,
  input  logic [NROWS-1:0]         wb_release,
  output logic                     grant_q,
  output logic [RIDX_W-1:0]        grant_row_q,
  output logic                     raw_q,
  output logic                     war_q,
  output logic                     waw_q,
  output logic                     nounit_q,
  output logic [NROWS-1:0]         tbl_busy,
  output logic [NROWS*OP_W-1:0]    tbl_op,
  output logic [NROWS*REG_W-1:0]   tbl_dest
);

  logic [NROWS-1:0]             busy_q, busy_eff, wr_en, sel_oh;
  logic [NROWS-1:0][OP_W-1:0]   op_q;
  logic [NROWS-1:0][REG_W-1:0]  dest_q, src1_q, src2_q;
  logic                         raw, war, waw, legal, found, go;
  logic [RIDX_W-1:0]            sel_row;

  fust_table #(.NROWS(NROWS), .REG_W(REG_W), .OP_W(OP_W)) u_table (
    .clk(clk), .rst(rst), .release_i(wb_release), .wr_en(wr_en),
    .wr_op(iss_op), .wr_dest(iss_dest), .wr_src1(iss_src1), .wr_src2(iss_src2),
    .busy_q(busy_q), .busy_eff(busy_eff), .op_q(op_q), .dest_q(dest_q),
    .src1_q(src1_q), .src2_q(src2_q)
  );

  fust_match #(.NROWS(NROWS), .REG_W(REG_W)) u_match (
    .busy_eff(busy_eff), .dest_q(dest_q), .src1_q(src1_q), .src2_q(src2_q),
    .iss_dest(iss_dest), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .raw(raw), .war(war), .waw(waw)
  );

  fust_alloc #(.NROWS(NROWS), .N_ADD(N_ADD), .N_MUL(N_MUL)) u_alloc (
    .clk(clk), .rst(rst), .busy_eff(busy_eff), .iss_class(iss_class),
    .legal(legal), .found(found), .sel_row(sel_row), .sel_oh(sel_oh)
  );

  assign go    = iss_valid && legal && found && !raw && !war && !waw;
  assign wr_en = go ? sel_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q     <= 1'b0;
      grant_row_q <= '0;
      raw_q       <= 1'b0;
      war_q       <= 1'b0;
      waw_q       <= 1'b0;
      nounit_q    <= 1'b0;
    end else begin
      grant_q     <= go;
      grant_row_q <= go ? sel_row : '0;
      raw_q       <= iss_valid && raw;
      war_q       <= iss_valid && war;
      waw_q       <= iss_valid && waw;
      nounit_q    <= iss_valid && !(legal && found);
    end
  end

  assign tbl_busy = busy_q;
  assign tbl_op   = op_q;
  assign tbl_dest = dest_q;

  // R4/R5/R6: a grant is never reported together with a hazard or a missing unit.
  assert_grant_clean_R4: assert property (@(posedge clk) disable iff (rst)
    grant_q |-> !(raw_q || war_q || waw_q || nounit_q));

  // R7: the granted row is occupied and carries the issued destination.
  assert_grant_row_filled_R7: assert property (@(posedge clk) disable iff (rst)
    grant_q |-> (busy_q[grant_row_q] && dest_q[grant_row_q] == $past(iss_dest)));

  // R9: nothing is reported for a cycle without a request.
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> !(grant_q || raw_q || war_q || waw_q || nounit_q));

endmodule

// File: tb/test_fu_status_table.sv
`timescale 1ns/1ps
module test_fu_status_table;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic [2:0]  iss_class = '0;
  logic [5:0]  iss_op = '0;
  logic [4:0]  iss_dest = '0, iss_src1 = '0, iss_src2 = '0;
  logic [7:0]  wb_release = '0;
  logic        grant_q, raw_q, war_q, waw_q, nounit_q;
  logic [2:0]  grant_row_q;
  logic [7:0]  tbl_busy;
  logic [47:0] tbl_op;
  logic [39:0] tbl_dest;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fu_status_table i_fu_status_table (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_op(iss_op), .iss_dest(iss_dest), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .wb_release(wb_release), .grant_q(grant_q), .grant_row_q(grant_row_q),
    .raw_q(raw_q), .war_q(war_q), .waw_q(waw_q), .nounit_q(nounit_q),
    .tbl_busy(tbl_busy), .tbl_op(tbl_op), .tbl_dest(tbl_dest)
  );

  // Reference model state
  bit [7:0]   m_busy = '0;
  logic [4:0] m_dst [8];
  logic [4:0] m_s1  [8];
  logic [4:0] m_s2  [8];
  logic [5:0] m_op  [8];

  function automatic int rowcls(input int r);
    case (r)
      0: return 0;
      1: return 1;
      2, 3, 4: return 2;
      5, 6: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string scen,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", req, scen, act, exp);
    end
  endtask

  task automatic step(input string scen, input bit v, input int c, input int o,
                      input int d, input int a, input int b, input bit [7:0] rel);
    bit [7:0] beff;
    bit e_raw, e_war, e_waw, e_nou, e_gnt, fnd;
    int row;
    @(negedge clk);
    iss_valid = v; iss_class = 3'(c); iss_op = 6'(o);
    iss_dest = 5'(d); iss_src1 = 5'(a); iss_src2 = 5'(b); wb_release = rel;
    beff = m_busy & ~rel;
    e_raw = 0; e_war = 0; e_waw = 0; fnd = 0; row = 0;
    for (int r = 0; r < 8; r++) begin
      if (beff[r]) begin
        if (m_dst[r] == 5'(a) || m_dst[r] == 5'(b)) e_raw = 1;
        if (m_s1[r] == 5'(d) || m_s2[r] == 5'(d))   e_war = 1;
        if (m_dst[r] == 5'(d))                      e_waw = 1;
      end
    end
    for (int r = 7; r >= 0; r--)
      if (rowcls(r) == c && !beff[r]) begin fnd = 1; row = r; end
    e_gnt = v && fnd && !e_raw && !e_war && !e_waw;
    e_nou = v && !fnd;
    e_raw = v && e_raw; e_war = v && e_war; e_waw = v && e_waw;
    @(posedge clk);
    #1;
    chk(grant_q == e_gnt, "R3", scen, grant_q, e_gnt);
    if (e_gnt) chk(grant_row_q == 3'(row), "R3", scen, grant_row_q, row);
    chk(raw_q == e_raw, "R4", scen, raw_q, e_raw);
    chk(war_q == e_war, "R5", scen, war_q, e_war);
    chk(waw_q == e_waw, "R6", scen, waw_q, e_waw);
    chk(nounit_q == e_nou, "R2", scen, nounit_q, e_nou);
    m_busy = beff;
    if (e_gnt) begin
      m_busy[row] = 1;
      m_dst[row] = 5'(d); m_s1[row] = 5'(a); m_s2[row] = 5'(b); m_op[row] = 6'(o);
    end
    chk(tbl_busy == m_busy, "R8", scen, tbl_busy, m_busy);
    for (int r = 0; r < 8; r++) begin
      if (m_busy[r]) begin
        chk(tbl_dest[r*5 +: 5] == m_dst[r], "R7", scen, tbl_dest[r*5 +: 5], m_dst[r]);
        chk(tbl_op[r*6 +: 6] == m_op[r], "R7", scen, tbl_op[r*6 +: 6], m_op[r]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(tbl_busy == 8'h00, "R1", "reset", tbl_busy, 0);
    chk({grant_q, raw_q, war_q, waw_q, nounit_q} == 5'b0, "R1", "reset",
        {grant_q, raw_q, war_q, waw_q, nounit_q}, 0);

    step("R3 int first", 1, 0, 7, 1, 2, 3, 8'h00);
    step("R3 int busy", 1, 0, 8, 9, 9, 9, 8'h00);
    step("R4 raw", 1, 2, 3, 4, 1, 8, 8'h00);
    step("R5 war", 1, 2, 3, 2, 5, 6, 8'h00);
    step("R6 waw", 1, 2, 3, 1, 5, 6, 8'h00);
    step("R3 add a", 1, 2, 11, 10, 20, 21, 8'h00);
    step("R3 add b", 1, 2, 12, 11, 20, 21, 8'h00);
    step("R3 add c", 1, 2, 13, 12, 20, 21, 8'h00);
    step("R3 add full", 1, 2, 14, 13, 22, 23, 8'h00);
    step("R8 free add b reuse", 1, 2, 15, 13, 22, 23, 8'h08);
    step("R8 free int reuse dest", 1, 0, 16, 1, 2, 3, 8'h01);
    step("R2 illegal class", 1, 6, 1, 25, 26, 27, 8'h00);
    step("R2 mem", 1, 1, 2, 26, 27, 28, 8'h00);
    step("R2 mult", 1, 3, 3, 27, 28, 29, 8'h00);
    step("R2 div", 1, 4, 4, 30, 31, 31, 8'h00);
    step("R9 idle", 0, 2, 5, 1, 1, 1, 8'h00);
    step("R10 release div", 0, 0, 0, 0, 0, 0, 8'h80);
    step("R10 stale names", 1, 4, 6, 31, 30, 31, 8'h00);
    step("R8 release all", 0, 0, 0, 0, 0, 0, 8'hFF);

    for (int i = 0; i < 600; i++) begin
      step("random", ($urandom % 4) != 0, $urandom % 6, $urandom % 64,
           $urandom % 8, $urandom % 8, $urandom % 8,
           8'($urandom & $urandom & $urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule